// File: doc/BRIEF.md
# CAN Multi-Object Acceptance Filter

This block decides which receive message objects take an incoming 11-bit CAN frame identifier. It keeps a bank of message objects, each with a programmable identifier and an enable bit. A single mask register is shared by all of them. A mask bit of 1 makes the matching identifier bit take part in the comparison, and a mask bit of 0 makes that bit irrelevant. Because the mask is shared, one identifier can be admitted by several objects at the same time.

The receive path presents each identifier with a one-cycle strobe. One clock later the block returns a per-object accept vector, a hit flag and the index of the lowest-numbered accepting object. That index tells the storage logic where to place the frame. When nothing matches, hit stays low and the frame is discarded. Software-side logic programs the mask, the object identifiers and the enables through simple write ports.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the mask is all ones (exact match), every object identifier is 0, every enable bit is 0, and accept, hit and index are 0.
- R2: An enabled object accepts a strobed identifier when every identifier bit whose mask bit is 1 equals the same bit of the object's identifier.
- R3: Identifier bits whose mask bit is 0 are not compared, and the one mask applies to every object. For example, with mask 0x7FC and objects 0..3 holding 1, 2, 3 and 4, identifier 1 gives accept 0x07 and identifier 4 gives accept 0x08.
- R4: An object whose enable bit is 0 never sets its accept bit.
- R5: The accept vector appears in the clock cycle after the strobe cycle. Bit i of accept corresponds to object i. The index output is the lowest i with a set accept bit, and hit is 1.
- R6: When no enabled object matches a strobed identifier, accept is 0, hit is 0 and the index is 0 in the following cycle.
- R7: In a cycle that follows a cycle without a strobe, accept, hit and index are 0.
- R8: A write to the mask, an object identifier or the enables changes the decision only for strobes in later cycles. A strobe in the same cycle as a write uses the values from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Write strobe for the shared mask |
| mask_wdata | input | 11 | New mask value |
| obj_we | input | 1 | Write strobe for one object identifier |
| obj_sel | input | 3 | Object selected for the identifier write |
| obj_wdata | input | 11 | New object identifier |
| en_we | input | 1 | Write strobe for the enable vector |
| en_wdata | input | 8 | New enable bits, bit i for object i |
| id_vld | input | 1 | Received identifier strobe |
| id_in | input | 11 | Received identifier |
| accept | output | 8 | Per-object accept vector, registered |
| hit | output | 1 | At least one object accepted |
| win_idx | output | 3 | Lowest accepting object |

## Verification
Several properties are checked on every clock: accept stays clear after a cycle without a strobe, no accept bit is set for an object that was disabled, the index points to the lowest set accept bit, and the index is 0 whenever hit is low. Whether the right objects were chosen depends on the programmed identifiers and mask, so only the bench can show it. The bench does this with the worked masking example, the reset values, and a same-cycle write racing a strobe. A behavioural model is also compared against the outputs on every clock while random writes and strobes are applied.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int NOBJ = 8,
  parameter int IDW  = 11,
  localparam int IXW = (NOBJ > 1) ? $clog2(NOBJ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [IDW-1:0]  mask_wdata,
  input  logic            obj_we,
  input  logic [IXW-1:0]  obj_sel,
  input  logic [IDW-1:0]  obj_wdata,
  input  logic            en_we,
  input  logic [NOBJ-1:0] en_wdata,
  input  logic            id_vld,
  input  logic [IDW-1:0]  id_in,
  output logic [NOBJ-1:0] accept,
  output logic            hit,
  output logic [IXW-1:0]  win_idx
);

  logic [IDW-1:0]  mask_q;
  logic [IDW-1:0]  oid_q [NOBJ];
  logic [NOBJ-1:0] en_q;
  logic [NOBJ-1:0] match;
  logic [NOBJ-1:0] acc_q;
  logic [IXW-1:0]  idx;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NOBJ; i++) begin
      if (!rst_n) oid_q[i] <= '0;
      else if (obj_we && obj_sel == IXW'(i)) oid_q[i] <= obj_wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < NOBJ; i++)
      match[i] = en_q[i] && (((id_in ^ oid_q[i]) & mask_q) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else acc_q <= id_vld ? match : '0;
  end

  always_comb begin
    idx = '0;
    for (int i = NOBJ - 1; i >= 0; i--)
      if (acc_q[i]) idx = IXW'(i);
  end

  assign accept  = acc_q;
  assign hit     = |acc_q;
  assign win_idx = idx;

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !id_vld |=> (accept == '0)); // R7
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept & ~$past(en_q)) == '0); // R4
  AST_LOWEST_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (accept[win_idx] && ((accept & ((NOBJ'(1) << win_idx) - NOBJ'(1))) == '0))); // R5
  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (win_idx == '0 && accept == '0)); // R6

endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mask_we = 0, obj_we = 0, en_we = 0, id_vld = 0;
  logic [10:0] mask_wdata = 0, obj_wdata = 0, id_in = 0;
  logic [2:0]  obj_sel = 0;
  logic [7:0]  en_wdata = 0;
  logic [7:0]  accept;
  logic        hit;
  logic [2:0]  win_idx;

  int tests = 0, fails = 0, cyc = 0;
  bit cmp_on = 0;

  logic [10:0] m_mask;
  logic [10:0] m_id [8];
  logic [7:0]  m_en, e_acc;

  always #10 clk = ~clk;

  can_accept_filter uut (.*);

  always @(posedge clk) begin
    logic [7:0] nxt;
    nxt = 0;
    if (id_vld)
      for (int i = 0; i < 8; i++)
        if (m_en[i] && (((id_in ^ m_id[i]) & m_mask) == 0)) nxt[i] = 1;
    if (!rst_n) begin
      m_mask = 11'h7FF; m_en = 0; e_acc = 0;
      for (int i = 0; i < 8; i++) m_id[i] = 0;
    end else begin
      e_acc = nxt;
      if (mask_we) m_mask = mask_wdata;
      if (en_we) m_en = en_wdata;
      if (obj_we) m_id[obj_sel] = obj_wdata;
    end
  end

  function automatic int low_idx(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      tests++;
      if (accept !== e_acc || hit !== (e_acc != 0) || win_idx !== 3'(low_idx(e_acc))) begin
        fails++;
        $display("FAIL R7 cycle model: acc=%h hit=%b idx=%0d exp acc=%h hit=%b idx=%0d",
                 accept, hit, win_idx, e_acc, e_acc != 0, low_idx(e_acc));
      end
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] ea, logic eh, logic [2:0] ei);
    tests++;
    if (accept !== ea || hit !== eh || win_idx !== ei) begin
      fails++;
      $display("FAIL %s: acc=%h hit=%b idx=%0d exp acc=%h hit=%b idx=%0d",
               tag, accept, hit, win_idx, ea, eh, ei);
    end
  endtask

  task automatic wr_mask(logic [10:0] v);
    @(negedge clk); mask_we = 1; mask_wdata = v; @(negedge clk); mask_we = 0;
  endtask
  task automatic wr_obj(int i, logic [10:0] v);
    @(negedge clk); obj_we = 1; obj_sel = 3'(i); obj_wdata = v; @(negedge clk); obj_we = 0;
  endtask
  task automatic wr_en(logic [7:0] v);
    @(negedge clk); en_we = 1; en_wdata = v; @(negedge clk); en_we = 0;
  endtask
  task automatic strobe(logic [10:0] v);
    @(negedge clk); id_vld = 1; id_in = v; @(negedge clk); id_vld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    chk("R1 reset outputs", 8'h00, 0, 0);
    strobe(11'h000);
    chk("R1 enables clear", 8'h00, 0, 0);
    wr_en(8'hFF);
    strobe(11'h000);
    chk("R1 ids zero", 8'hFF, 1, 0);
    strobe(11'h001);
    chk("R1 mask all ones", 8'h00, 0, 0);
    chk("R6 miss", 8'h00, 0, 0);
    @(negedge clk);
    chk("R7 idle", 8'h00, 0, 0);

    for (int i = 0; i < 8; i++) wr_obj(i, 11'(i + 1));
    wr_en(8'h0F);
    wr_mask(11'h7FC);
    strobe(11'h001);
    chk("R3 shared mask id1", 8'h07, 1, 0);
    strobe(11'h003);
    chk("R3 shared mask id3", 8'h07, 1, 0);
    strobe(11'h004);
    chk("R3 shared mask id4", 8'h08, 1, 3);
    strobe(11'h404);
    chk("R2 masked bit differs", 8'h00, 0, 0);
    wr_mask(11'h7FF);
    strobe(11'h002);
    chk("R2 exact", 8'h02, 1, 1);
    wr_mask(11'h7FC);
    wr_en(8'h0E);
    strobe(11'h001);
    chk("R4 obj0 disabled", 8'h06, 1, 1);
    chk("R5 lowest index", 8'h06, 1, 1);

    @(negedge clk);
    obj_we = 1; obj_sel = 3; obj_wdata = 11'h001; id_vld = 1; id_in = 11'h001;
    @(negedge clk);
    obj_we = 0; id_vld = 0;
    chk("R8 same-cycle write uses old", 8'h06, 1, 1);
    strobe(11'h001);
    chk("R8 write applied later", 8'h0E, 1, 1);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      mask_we = ($urandom % 16) == 0;
      mask_wdata = 11'h7F0 | 11'($urandom % 16);
      obj_we = ($urandom % 4) == 0;
      obj_sel = 3'($urandom);
      obj_wdata = 11'($urandom % 16);
      en_we = ($urandom % 16) == 0;
      en_wdata = 8'($urandom);
      id_vld = ($urandom % 3) != 0;
      id_in = 11'($urandom % 16);
    end
    @(negedge clk);
    mask_we = 0; obj_we = 0; en_we = 0; id_vld = 0;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule